// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a small 8-bit datapath. It holds an accumulator and a second operand register. On each cycle where an operation strobe is raised, it combines the accumulator with the operand register. The result goes back into the accumulator and refreshes five flag flip-flops: sign, zero, nibble carry, even parity and carry/borrow. The surrounding logic loads the accumulator and the operand register through plain load ports, raises the strobe with an operation code, and reads the accumulator and a packed status byte.

Every port is a plain control or data pin sampled on the rising clock edge. The block has no stream interface. It accepts one operation per cycle and has no back-pressure, so the caller never waits. Results appear on the register outputs one clock after the strobe.

Top module: `acc_alu`

## Requirements
- R1: A synchronous reset clears the accumulator, the operand register and all five flags, so the status byte reads 0x02 after reset.
- R2: The operation codes are ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6 and CMP=7. Every code except CMP writes its result into the accumulator one clock after the strobe; CMP leaves the accumulator unchanged.
- R3: When `acc_load` is high and no strobe is present, the accumulator takes `acc_din`. When the strobe and `acc_load` are both high, the operation result wins.
- R4: The sign flag equals bit 7 of the 8-bit result.
- R5: The zero flag is set exactly when the 8-bit result is all zeros.
- R6: The parity flag is set when the result has an even number of 1 bits and is cleared when the count is odd.
- R7: The nibble carry flag is the carry out of bit 3 of the low-nibble sum. For an add this sum is a + b + cin. For a subtract or compare it is a + ~b + (1 − borrow_in).
- R8: For ADD and ADC the carry flag is the carry out of bit 7. For SUB, SBB and CMP it is the borrow, set when the subtrahend plus the borrow-in exceeds the minuend. ADC and SBB take the current carry flag as their carry-in or borrow-in; ADD, SUB and CMP use 0.
- R9: AND, OR and XOR clear the carry flag. AND sets the nibble carry flag; OR and XOR clear it.
- R10: The status byte reads bit7=sign, bit6=zero, bit4=nibble carry, bit2=parity, bit0=carry. Bit 1 always reads 1, and bits 5 and 3 always read 0.
- R11: Without a strobe, the flags and accumulator hold, whatever `op_sel` does; the accumulator changes only through `acc_load`. The operand register changes only on `tmp_load`. An operation in the same cycle as `tmp_load` uses the previous operand value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_load | input | 1 | Load the accumulator from acc_din |
| acc_din | input | 8 | Accumulator load value |
| tmp_load | input | 1 | Load the operand register from tmp_din |
| tmp_din | input | 8 | Operand register load value |
| op_strobe | input | 1 | Execute op_sel this cycle |
| op_sel | input | 3 | Operation code |
| acc_q | output | 8 | Accumulator contents |
| tmp_q | output | 8 | Operand register contents |
| status_q | output | 8 | Packed flag byte |

## Verification
The operations run over a chain of operand pairs, each picked to separate one flag cause from another:
- A sum that wraps to zero sets carry, nibble carry and zero together.
- An add-with-carry and a subtract-with-borrow consume the carry left by the previous operation, which tells a chained carry-in from a constant one.
- A pair of subtractions, one crossing zero and one not, tells a borrow from a carry.
- A pair of compares, one equal and one unequal, shows the flags moving while the accumulator stays put.
- Logic results with odd and even bit counts separate the parity sense and the fixed AND/OR/XOR nibble carry.

Directed cases then cover port precedence: a load colliding with a strobe, an operand load colliding with an operation, strobe-free cycles with busy inputs, and reset in the middle of a run.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_ADC = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_SBB = 3'd3;
  localparam logic [2:0] OP_AND = 3'd4;
  localparam logic [2:0] OP_OR  = 3'd5;
  localparam logic [2:0] OP_XOR = 3'd6;
  localparam logic [2:0] OP_CMP = 3'd7;

  typedef struct packed {
    logic sgn;
    logic zro;
    logic nib;
    logic par;
    logic cry;
  } flags_t;

  function automatic logic [7:0] pack_status(flags_t f);
    return {f.sgn, f.zro, 1'b0, f.nib, 1'b0, f.par, 1'b1, f.cry};
  endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin_flag,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         nib_out
);
  logic [W-1:0]   b_eff;
  logic           c0;
  logic [W:0]     full;
  logic [NIB:0]   low;

  always_comb begin
    b_eff   = sub ? ~b : b;
    c0      = sub ? ~cin_flag : cin_flag;
    full    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    low     = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c0};
    res     = full[W-1:0];
    cy_out  = sub ? ~full[W] : full[W];
    nib_out = low[NIB];
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] res,
  output logic         nib_out
);
  always_comb begin
    unique case (fn)
      2'd0:    res = a & b;
      2'd1:    res = a | b;
      default: res = a ^ b;
    endcase
    nib_out = (fn == 2'd0);
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  input  logic         cy,
  input  logic         nib,
  output flags_t       f
);
  always_comb begin
    f.sgn = res[W-1];
    f.zro = (res == '0);
    f.nib = nib;
    f.par = ~^res;
    f.cry = cy;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         acc_load,
  input  logic [W-1:0] acc_din,
  input  logic         tmp_load,
  input  logic [W-1:0] tmp_din,
  input  logic         op_strobe,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] tmp_q,
  output logic [7:0]   status_q
);
  logic [W-1:0] acc_r, tmp_r;
  flags_t       flg_r, flg_nx;

  logic         is_logic, is_sub, use_cin;
  logic [W-1:0] ar_res, lg_res, res;
  logic         ar_cy, ar_nib, lg_nib;
  logic         nib_sel, cy_sel;

  always_comb begin
    is_logic = op_sel[2] && (op_sel != OP_CMP);
    is_sub   = op_sel[1] && !is_logic;
    use_cin  = (op_sel == OP_ADC) || (op_sel == OP_SBB);
  end

  acc_alu_arith #(.W(W), .NIB(NIB)) u_arith (
    .a(acc_r), .b(tmp_r), .sub(is_sub), .cin_flag(use_cin & flg_r.cry),
    .res(ar_res), .cy_out(ar_cy), .nib_out(ar_nib)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a(acc_r), .b(tmp_r), .fn(op_sel[1:0]), .res(lg_res), .nib_out(lg_nib)
  );

  always_comb begin
    res     = is_logic ? lg_res : ar_res;
    nib_sel = is_logic ? lg_nib : ar_nib;
    cy_sel  = is_logic ? 1'b0   : ar_cy;
  end

  acc_alu_flags #(.W(W)) u_flags (
    .res(res), .cy(cy_sel), .nib(nib_sel), .f(flg_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r <= '0;
      tmp_r <= '0;
      flg_r <= '0;
    end else begin
      if (tmp_load) tmp_r <= tmp_din;
      if (op_strobe) begin
        flg_r <= flg_nx;
        if (op_sel != OP_CMP) acc_r <= res;
      end else if (acc_load) begin
        acc_r <= acc_din;
      end
    end
  end

  assign acc_q    = acc_r;
  assign tmp_q    = tmp_r;
  assign status_q = pack_status(flg_r);
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         acc_load,
  input logic         tmp_load,
  input logic         op_strobe,
  input logic [2:0]   op_sel,
  input logic [W-1:0] acc_q,
  input logic [W-1:0] tmp_q,
  input logic [7:0]   status_q
);
  logic lg_op;
  assign lg_op = op_sel[2] && (op_sel != OP_CMP);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && tmp_q == '0 && status_q == 8'h02));

  assert_cmp_keeps_acc_R2: assert property (@(posedge clk) disable iff (rst)
    (op_strobe && op_sel == OP_CMP) |=> $stable(acc_q));

  assert_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (op_strobe && op_sel != OP_CMP) |=> (status_q[7] == acc_q[W-1]));

  assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (op_strobe && op_sel != OP_CMP) |=> (status_q[6] == (acc_q == '0)));

  assert_parity_R6: assert property (@(posedge clk) disable iff (rst)
    (op_strobe && op_sel != OP_CMP) |=> (status_q[2] == ~^acc_q));

  assert_logic_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (op_strobe && lg_op) |=> (!status_q[0] && status_q[4] == ($past(op_sel) == OP_AND)));

  assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (rst)
    (status_q[5] == 1'b0 && status_q[3] == 1'b0 && status_q[1] == 1'b1));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !op_strobe |=> $stable(status_q));

  assert_acc_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!op_strobe && !acc_load) |=> $stable(acc_q));

  assert_tmp_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !tmp_load |=> $stable(tmp_q));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .acc_load(acc_load), .tmp_load(tmp_load),
  .op_strobe(op_strobe), .op_sel(op_sel), .acc_q(acc_q), .tmp_q(tmp_q),
  .status_q(status_q)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       acc_load, tmp_load, op_strobe;
  logic [7:0] acc_din, tmp_din;
  logic [2:0] op_sel;
  logic [7:0] acc_q, tmp_q, status_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst(rst), .acc_load(acc_load), .acc_din(acc_din),
    .tmp_load(tmp_load), .tmp_din(tmp_din), .op_strobe(op_strobe),
    .op_sel(op_sel), .acc_q(acc_q), .tmp_q(tmp_q), .status_q(status_q)
  );

  // {op, a, b, expected acc, expected status}; carry chains between rows
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {4'd0, 8'h3A, 8'hC6, 8'h00, 8'h57},  // ADD wraps to zero
    {4'd1, 8'h10, 8'h20, 8'h31, 8'h02},  // ADC with carry-in 1
    {4'd2, 8'h05, 8'h07, 8'hFE, 8'h83},  // SUB borrow
    {4'd3, 8'h50, 8'h10, 8'h3F, 8'h06},  // SBB with borrow-in 1
    {4'd4, 8'hF0, 8'h3C, 8'h30, 8'h16},  // AND
    {4'd5, 8'h81, 8'h02, 8'h83, 8'h82},  // OR odd parity
    {4'd6, 8'h5A, 8'h5A, 8'h00, 8'h46},  // XOR to zero
    {4'd7, 8'h20, 8'h21, 8'h20, 8'h87},  // CMP less
    {4'd7, 8'h42, 8'h42, 8'h42, 8'h56},  // CMP equal
    {4'd2, 8'h10, 8'h01, 8'h0F, 8'h06},  // SUB no borrow
    {4'd0, 8'h0F, 8'h01, 8'h10, 8'h12},  // ADD nibble carry
    {4'd1, 8'hFF, 8'h00, 8'hFF, 8'h86}   // ADC carry-in 0
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    acc_load = 0; tmp_load = 0; op_strobe = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; idle(); acc_din = 0; tmp_din = 0; op_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", "reset acc", acc_q, 8'h00);
    check("R1", "reset tmp", tmp_q, 8'h00);
    check("R1 R10", "reset status", status_q, 8'h02);

    for (int i = 0; i < NV; i++) begin
      acc_load = 1; acc_din = VEC[i][31:24];
      tmp_load = 1; tmp_din = VEC[i][23:16];
      @(negedge clk);
      idle(); op_strobe = 1; op_sel = VEC[i][34:32];
      @(negedge clk);
      idle();
      check("R2 R8 R9", $sformatf("vec %0d acc", i), acc_q, VEC[i][15:8]);
      check("R4 R5 R6 R7 R8 R9 R10", $sformatf("vec %0d status", i), status_q, VEC[i][7:0]);
    end

    // R11: strobe low with busy inputs: nothing moves
    for (int k = 0; k < 3; k++) begin
      op_sel = 3'(k); acc_din = 8'hA5 + 8'(k); tmp_din = 8'h3C + 8'(k);
      @(negedge clk);
    end
    check("R11", "hold acc", acc_q, 8'hFF);
    check("R11", "hold status", status_q, 8'h86);
    check("R11", "hold tmp", tmp_q, 8'h00);

    // R3: strobe beats acc_load
    acc_load = 1; acc_din = 8'h01; tmp_load = 1; tmp_din = 8'h02;
    @(negedge clk);
    idle(); op_strobe = 1; op_sel = 3'd0; acc_load = 1; acc_din = 8'h55;
    @(negedge clk);
    idle();
    check("R3", "strobe wins over load", acc_q, 8'h03);

    // R11: operation alongside tmp_load uses old operand
    op_strobe = 1; op_sel = 3'd0; tmp_load = 1; tmp_din = 8'h10;
    @(negedge clk);
    idle();
    check("R11", "old operand used", acc_q, 8'h05);
    check("R11", "operand loaded", tmp_q, 8'h10);
    check("R6", "even parity 0x05", status_q, 8'h06);

    // R3: plain load leaves flags
    acc_load = 1; acc_din = 8'h9C;
    @(negedge clk);
    idle();
    check("R3", "plain load", acc_q, 8'h9C);
    check("R11", "flags after load", status_q, 8'h06);

    // R1: reset mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1", "mid reset acc", acc_q, 8'h00);
    check("R1", "mid reset tmp", tmp_q, 8'h00);
    check("R1", "mid reset status", status_q, 8'h02);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule